// File: doc/BRIEF.md
# Three-Stage Fetch Pipeline Controller

This block sequences the front end of a 32-bit processor that runs either wide 4-byte instructions or compact 2-byte instructions. It holds two instruction slots, the most recent fetch and the one ahead of it (the decoded slot). It owns the program counter and, on each advance step, fetches one word at that counter. Once both slots are full, the older one is handed to the execute logic. Decoding and executing the instruction are done outside the block.

A redirect empties the pipeline and loads a new, aligned program counter. A redirect comes from an external flush request (branch or exception) or from an executing instruction that wrote the counter. After a redirect, the pipeline needs two fetch steps to refill before any instruction executes again. Every fetch is marked sequential or non-sequential by comparing its address with the previous fetch address. Each fetch is charged one cycle plus a wait-state count supplied by the memory side, and the running total is visible as an output. The block also reports the address of the next instruction to execute.

Top module: `fetch_pipe_ctrl`

## Requirements
- R1: After reset the fetch address is RESET_PC (default 0), no instruction is valid, the cycle total is 0, and the last-fetch register holds 0xFFFF0000, so the first fetch from address 0 is non-sequential.
- R2: After reset or any redirect, the first two fetch steps present no valid instruction; the third fetch step presents one.
- R3: The instruction presented for execution is the fetch data captured two fetch steps earlier.
- R4: A fetch step without a redirect advances the fetch address by 4 when `compact_i`=0 and by 2 when `compact_i`=1.
- R5: `next_pc_o` equals the fetch address with 0 slots full, the fetch address minus one instruction size with 1 slot full, and the fetch address minus two sizes with 2 slots full.
- R6: `flush_i` takes priority over advance: that cycle performs no fetch and executes nothing, charges no cycles, empties both slots, and loads the target.
- R7: When a valid instruction executes with `pc_wr_i`=1, the fetch of that step still counts, both slots are emptied, and the fetch address becomes the target.
- R8: A fetch is sequential (`fetch_seq_o`=1) when its address equals the previous fetch address or that address plus the current instruction size; otherwise it is non-sequential.
- R9: Each fetch adds 1 + `wait_i` to `cycles_o`; a cycle without a fetch leaves it unchanged.
- R10: A redirect target is aligned to the instruction size: bits [1:0] are cleared in wide mode and bit 0 is cleared in compact mode.
- R11: `pc_wr_i` has no effect when no valid instruction is being executed.
- R12: With `adv_i`=0 and no flush, the fetch address, slots, cycle total and next-instruction address are all held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| adv_i | input | 1 | Advance the pipeline by one fetch step |
| compact_i | input | 1 | 1 = 2-byte instructions, 0 = 4-byte instructions |
| flush_i | input | 1 | Redirect request (branch or exception) |
| target_i | input | AW | Redirect target address |
| pc_wr_i | input | 1 | The executing instruction wrote the program counter |
| fetch_data_i | input | DW | Word returned for the current fetch |
| wait_i | input | WW | Wait states of the current fetch |
| fetch_addr_o | output | AW | Current fetch address (program counter) |
| fetch_req_o | output | 1 | A fetch is performed this cycle |
| fetch_seq_o | output | 1 | The current fetch is sequential |
| exec_valid_o | output | 1 | `exec_insn_o` executes this cycle |
| exec_insn_o | output | DW | Instruction handed to execute |
| next_pc_o | output | AW | Address of the next instruction to execute |
| cycles_o | output | CW | Accumulated access cycles |

## Verification
The bound checker checks the following on every cycle:
- The cycle charge per fetch.
- The hold of address and cycle total when idle.
- The advance of the fetch address by one instruction size.
- The aligned target load after a flush.
- The absence of a valid instruction right after a flush.
- The relation between the next-instruction address and the fetch address during execution.

Only the bench's scenarios can show the following:
- The slot contents arriving at execute two fetches later.
- The refill count after both kinds of redirect.
- Sequential classification when a redirect lands on or just past the previous fetch.
- Mode switches in the middle of a run.

// File: rtl/fpc_pkg.sv
package fpc_pkg;
  typedef enum logic [1:0] {
    ST_FILL0 = 2'd0,
    ST_FILL1 = 2'd1,
    ST_RUN   = 2'd2
  } pipe_state_e;
endpackage

// File: rtl/fpc_stage_fsm.sv
module fpc_stage_fsm
  import fpc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        fetch_i,
  input  logic        redirect_i,
  output pipe_state_e state_o
);
  pipe_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (redirect_i) begin
      state_d = ST_FILL0;
    end else if (fetch_i) begin
      unique case (state_q)
        ST_FILL0: state_d = ST_FILL1;
        ST_FILL1: state_d = ST_RUN;
        default:  state_d = ST_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_FILL0;
    else        state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/fpc_pc_unit.sv
module fpc_pc_unit
  import fpc_pkg::*;
#(
  parameter int unsigned AW       = 32,
  parameter logic [AW-1:0] RESET_PC = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fetch_i,
  input  logic          redirect_i,
  input  logic          compact_i,
  input  logic [AW-1:0] target_i,
  input  pipe_state_e   state_i,
  output logic [AW-1:0] pc_o,
  output logic [AW-1:0] next_pc_o
);
  localparam logic [AW-1:0] WIDE_SZ = AW'(4);
  localparam logic [AW-1:0] COMP_SZ = AW'(2);

  logic [AW-1:0] pc_q, pc_d, size, aligned;
  logic          pc_en;

  assign size    = compact_i ? COMP_SZ : WIDE_SZ;
  assign aligned = compact_i ? {target_i[AW-1:1], 1'b0} : {target_i[AW-1:2], 2'b00};
  assign pc_en   = redirect_i | fetch_i;

  always_comb begin
    if (redirect_i) pc_d = aligned;
    else            pc_d = pc_q + size;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pc_q <= RESET_PC;
    else if (pc_en) pc_q <= pc_d;
  end

  always_comb begin
    unique case (state_i)
      ST_FILL0: next_pc_o = pc_q;
      ST_FILL1: next_pc_o = pc_q - size;
      default:  next_pc_o = pc_q - (size << 1);
    endcase
  end

  assign pc_o = pc_q;
endmodule

// File: rtl/fpc_access_track.sv
module fpc_access_track #(
  parameter int unsigned AW = 32,
  parameter int unsigned CW = 32,
  parameter int unsigned WW = 4,
  parameter logic [AW-1:0] NO_ADDR = 32'hFFFF_0000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fetch_i,
  input  logic          compact_i,
  input  logic [AW-1:0] addr_i,
  input  logic [WW-1:0] wait_i,
  output logic          seq_o,
  output logic [CW-1:0] cycles_o
);
  logic [AW-1:0] last_q;
  logic [CW-1:0] cyc_q, cyc_d;
  logic [AW-1:0] size;

  assign size  = compact_i ? AW'(2) : AW'(4);
  assign seq_o = (addr_i == last_q) || (addr_i == last_q + size);
  assign cyc_d = cyc_q + CW'(1) + CW'(wait_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= NO_ADDR;
      cyc_q  <= '0;
    end else if (fetch_i) begin
      last_q <= addr_i;
      cyc_q  <= cyc_d;
    end
  end

  assign cycles_o = cyc_q;
endmodule

// File: rtl/fetch_pipe_ctrl.sv
module fetch_pipe_ctrl
  import fpc_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32,
  parameter int unsigned CW = 32,
  parameter int unsigned WW = 4,
  parameter logic [AW-1:0] RESET_PC = '0,
  parameter logic [AW-1:0] NO_ADDR  = 32'hFFFF_0000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv_i,
  input  logic          compact_i,
  input  logic          flush_i,
  input  logic [AW-1:0] target_i,
  input  logic          pc_wr_i,
  input  logic [DW-1:0] fetch_data_i,
  input  logic [WW-1:0] wait_i,
  output logic [AW-1:0] fetch_addr_o,
  output logic          fetch_req_o,
  output logic          fetch_seq_o,
  output logic          exec_valid_o,
  output logic [DW-1:0] exec_insn_o,
  output logic [AW-1:0] next_pc_o,
  output logic [CW-1:0] cycles_o
);
  localparam int unsigned SLOTS = 2;

  pipe_state_e   state;
  logic          redirect;
  logic [DW-1:0] slot_q [SLOTS];
  logic [DW-1:0] slot_d [SLOTS];

  assign fetch_req_o  = adv_i & ~flush_i;
  assign exec_valid_o = fetch_req_o & (state == ST_RUN);
  assign redirect     = flush_i | (exec_valid_o & pc_wr_i);

  always_comb begin
    for (int i = 0; i < SLOTS - 1; i++) slot_d[i] = slot_q[i+1];
    slot_d[SLOTS-1] = fetch_data_i;
  end

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           slot_q[g] <= '0;
      else if (fetch_req_o) slot_q[g] <= slot_d[g];
    end
  end

  assign exec_insn_o = slot_q[0];

  fpc_stage_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .fetch_i    (fetch_req_o),
    .redirect_i (redirect),
    .state_o    (state)
  );

  fpc_pc_unit #(.AW(AW), .RESET_PC(RESET_PC)) u_pc (
    .clk        (clk),
    .rst_n      (rst_n),
    .fetch_i    (fetch_req_o),
    .redirect_i (redirect),
    .compact_i  (compact_i),
    .target_i   (target_i),
    .state_i    (state),
    .pc_o       (fetch_addr_o),
    .next_pc_o  (next_pc_o)
  );

  fpc_access_track #(.AW(AW), .CW(CW), .WW(WW), .NO_ADDR(NO_ADDR)) u_trk (
    .clk       (clk),
    .rst_n     (rst_n),
    .fetch_i   (fetch_req_o),
    .compact_i (compact_i),
    .addr_i    (fetch_addr_o),
    .wait_i    (wait_i),
    .seq_o     (fetch_seq_o),
    .cycles_o  (cycles_o)
  );
endmodule

// File: rtl/fpc_chk.sv
module fpc_chk #(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32,
  parameter int unsigned CW = 32,
  parameter int unsigned WW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          adv_i,
  input logic          compact_i,
  input logic          flush_i,
  input logic [AW-1:0] target_i,
  input logic          pc_wr_i,
  input logic [WW-1:0] wait_i,
  input logic [AW-1:0] fetch_addr_o,
  input logic          fetch_req_o,
  input logic          exec_valid_o,
  input logic [AW-1:0] next_pc_o,
  input logic [CW-1:0] cycles_o
);
  logic [AW-1:0] sz;
  logic [AW-1:0] tgt_al;
  assign sz     = compact_i ? AW'(2) : AW'(4);
  assign tgt_al = compact_i ? {target_i[AW-1:1], 1'b0} : {target_i[AW-1:2], 2'b00};

  // R9
  cycle_charge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req_o |=> cycles_o == $past(cycles_o) + CW'(1) + CW'($past(wait_i)));

  // R12
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv_i && !flush_i) |=> ($stable(fetch_addr_o) && $stable(cycles_o)));

  // R4
  pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_req_o && !(exec_valid_o && pc_wr_i)) |=> fetch_addr_o == $past(fetch_addr_o) + $past(sz));

  // R10
  flush_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> fetch_addr_o == $past(tgt_al));

  // R2
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> !exec_valid_o);

  // R5
  next_pc_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exec_valid_o |-> next_pc_o == fetch_addr_o - (sz << 1));
endmodule

bind fetch_pipe_ctrl fpc_chk #(.AW(AW), .DW(DW), .CW(CW), .WW(WW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .adv_i        (adv_i),
  .compact_i    (compact_i),
  .flush_i      (flush_i),
  .target_i     (target_i),
  .pc_wr_i      (pc_wr_i),
  .wait_i       (wait_i),
  .fetch_addr_o (fetch_addr_o),
  .fetch_req_o  (fetch_req_o),
  .exec_valid_o (exec_valid_o),
  .next_pc_o    (next_pc_o),
  .cycles_o     (cycles_o)
);

// File: tb/fetch_pipe_ctrl_tb_top.sv
`timescale 1ns/1ps
module fetch_pipe_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        adv_i = 1'b0, compact_i = 1'b0, flush_i = 1'b0, pc_wr_i = 1'b0;
  logic [31:0] target_i = '0, fetch_data_i = '0;
  logic [3:0]  wait_i = '0;
  logic [31:0] fetch_addr_o, exec_insn_o, next_pc_o, cycles_o;
  logic        fetch_req_o, fetch_seq_o, exec_valid_o;

  always #2 clk = ~clk;

  fetch_pipe_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .adv_i(adv_i), .compact_i(compact_i),
    .flush_i(flush_i), .target_i(target_i), .pc_wr_i(pc_wr_i),
    .fetch_data_i(fetch_data_i), .wait_i(wait_i),
    .fetch_addr_o(fetch_addr_o), .fetch_req_o(fetch_req_o),
    .fetch_seq_o(fetch_seq_o), .exec_valid_o(exec_valid_o),
    .exec_insn_o(exec_insn_o), .next_pc_o(next_pc_o), .cycles_o(cycles_o)
  );

  // behavioural reference state
  logic [31:0] m_pc, m_last, m_cyc;
  logic [31:0] m_q[$];
  int          n_chk = 0, n_bad = 0;
  string       tag = "";
  bit          done = 1'b0;
  logic [31:0] lfsr = 32'h1D2C_3B4A;

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] align(input logic [31:0] t, input logic cm);
    return cm ? (t & ~32'h1) : (t & ~32'h3);
  endfunction

  task automatic step(input logic adv, input logic fl, input logic [31:0] tgt,
                      input logic pw, input logic cm, input logic [31:0] dat,
                      input logic [3:0] ws);
    logic [31:0] sz;
    logic        e_fetch, e_exec, red;
    @(negedge clk);
    adv_i = adv; flush_i = fl; target_i = tgt; pc_wr_i = pw;
    compact_i = cm; fetch_data_i = dat; wait_i = ws;
    #1;
    sz      = cm ? 32'd2 : 32'd4;
    e_fetch = adv && !fl;
    e_exec  = e_fetch && (m_q.size() == 2);
    chk("R4 fetch address", fetch_addr_o, m_pc);
    chk("R6 fetch request", {31'b0, fetch_req_o}, {31'b0, e_fetch});
    chk("R2 exec valid", {31'b0, exec_valid_o}, {31'b0, e_exec});
    chk("R5 next pc", next_pc_o, m_pc - sz * 32'(m_q.size()));
    chk("R9 cycle total", cycles_o, m_cyc);
    if (e_exec) chk("R3 exec insn", exec_insn_o, m_q[0]);
    if (e_fetch)
      chk("R8 sequential", {31'b0, fetch_seq_o},
          {31'b0, (m_pc == m_last) || (m_pc == m_last + sz)});
    @(posedge clk);
    red = fl || (e_exec && pw);
    if (e_fetch) begin
      m_cyc  = m_cyc + 32'd1 + 32'(ws);
      m_last = m_pc;
    end
    if (red) begin
      m_pc = align(tgt, cm);
      m_q.delete();
    end else if (e_fetch) begin
      if (m_q.size() == 2) void'(m_q.pop_front());
      m_q.push_back(dat);
      m_pc = m_pc + sz;
    end
  endtask

  task automatic run(input int n, input logic cm);
    for (int i = 0; i < n; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      step(1'b1, 1'b0, '0, 1'b0, cm, lfsr ^ 32'hC0DE_0000, lfsr[3:0]);
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    m_pc = 32'h0; m_last = 32'hFFFF_0000; m_cyc = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    tag = "R1 reset";
    step(1'b1, 1'b0, '0, 1'b0, 1'b0, 32'hA000_0001, 4'd0);
    chk("R1 first fetch non-seq", {31'b0, fetch_seq_o}, 32'd0);

    tag = "R2 refill";
    step(1'b1, 1'b0, '0, 1'b0, 1'b0, 32'hA000_0002, 4'd2);
    step(1'b1, 1'b0, '0, 1'b0, 1'b0, 32'hA000_0003, 4'd1);
    tag = "R3 run wide";
    run(6, 1'b0);

    tag = "R12 idle";
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0, '0, 1'b1, 1'b0, 32'hDEAD_BEEF, 4'd7);

    tag = "R6 flush with advance";
    step(1'b1, 1'b1, 32'h0000_0100, 1'b0, 1'b0, 32'hBAD0_0000, 4'd5);
    run(5, 1'b0);

    tag = "R7 executed pc write";
    step(1'b1, 1'b0, 32'h0000_0200, 1'b1, 1'b0, 32'hB000_0001, 4'd3);
    tag = "R11 pc write during refill";
    step(1'b1, 1'b0, 32'h0000_0900, 1'b1, 1'b0, 32'hB000_0002, 4'd0);
    step(1'b1, 1'b0, 32'h0000_0900, 1'b1, 1'b0, 32'hB000_0003, 4'd0);
    run(3, 1'b0);

    tag = "R10 wide align";
    step(1'b0, 1'b1, 32'h0000_0303, 1'b0, 1'b0, 32'h0, 4'd0);
    run(4, 1'b0);
    tag = "R10 compact align";
    step(1'b0, 1'b1, 32'h0000_0407, 1'b0, 1'b1, 32'h0, 4'd0);
    run(6, 1'b1);

    tag = "R8 redirect onto last";
    step(1'b0, 1'b1, m_last, 1'b0, 1'b1, 32'h0, 4'd0);
    run(3, 1'b1);
    tag = "R8 redirect past last";
    step(1'b0, 1'b1, m_last + 32'd2, 1'b0, 1'b1, 32'h0, 4'd0);
    run(3, 1'b1);

    tag = "R3 mixed";
    for (int i = 0; i < 400; i++) begin
      logic adv, fl, pw, cm;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      adv = lfsr[5] | lfsr[6];
      fl  = (lfsr[11:8] == 4'hF);
      pw  = (lfsr[15:13] == 3'd0);
      cm  = lfsr[20] & lfsr[21];
      step(adv, fl, {16'h0, lfsr[31:16]}, pw, cm, lfsr ^ 32'h5A5A_0000, lfsr[27:24]);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule